// File: doc/BRIEF.md
# Prescaled Compare Timer

This block keeps a 32-bit time count. The count advances once per basic time unit. A programmable prescaler derives the time unit from the core clock by dividing it by n+2. The divide value n comes from an 8-bit field of a write-only control word. A compare register sits beside the count. Whenever the count has reached or passed the compare value, the block holds a level interrupt high. A single register write port loads the control word, the count and the compare value. A combinational read port returns the count and the compare value.

A flag in each control word chooses when the new setting takes effect. With the flag clear, the new divide value and clock-select code apply on the next cycle, and the prescaler restarts its time unit. With the flag set, the new setting waits as a pending value. It applies only when the running time unit ends, so a change of rate never stretches or cuts short the unit in progress. The block stores a 2-bit clock-select code and presents it on an output. It performs no clock switching itself.

Top module: `psc_timer_top`

## Requirements
- R1: The prescaler period is n+2 clock cycles, where n is bits 23..16 of the last applied control word. `tick_o` is a one-cycle pulse in the last cycle of each unit. The first pulse after an immediate control write appears n+1 cycles after the write edge.
- R2: On each `tick_o` pulse the count increases by one at the following clock edge. A direct count write in the same cycle overrides this, as R9 states.
- R3: The count wraps from 0xFFFFFFFF to 0.
- R4: `irq_o` is high exactly when the count is greater than or equal to the compare value, compared as unsigned numbers.
- R5: A control write with bit 31 = 0 sets n and the clock-select code from the next cycle on. It restarts the prescaler at the beginning of a unit and discards any pending setting.
- R6: A control write with bit 31 = 1 leaves the unit in progress at its old length. The new n and clock-select code take effect at the edge that ends that unit. A deferred write made in the same cycle as a `tick_o` pulse waits for the following boundary.
- R7: When several deferred writes arrive before one boundary, only the last of them is applied.
- R8: Bits 27..26 of the applied control word appear on `clk_sel_o`.
- R9: A write to the count register loads the written value. If a `tick_o` pulse occurs in the same cycle, the written value wins.
- R10: The register addresses are 0 = control word, 1 = count and 2 = compare. Reads return the count at address 1 and the compare value at address 2. Reads of address 0 and address 3 return zero.
- R11: After reset n = 0, the count is 0, the clock-select code is 0, the compare value is 0xFFFFFFFF and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Write address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 2 | Read address |
| reg_rdata | output | 32 | Read data (combinational) |
| tick_o | output | 1 | End-of-time-unit pulse |
| irq_o | output | 1 | Compare interrupt level |
| clk_sel_o | output | 2 | Applied clock-select code |

## Verification
The bench counts the cycles between `tick_o` pulses around both kinds of control write:
- A design that applied a deferred write at once would cut the current unit short or stretch it.
- A design that let an older pending value outlive a newer one would run at the wrong period after the boundary.

The bench writes the count in exactly the cycle of a tick pulse, so a design that gives the carry priority over the write ends one count high. It also exercises the compare across the sign bit and across the wrap, so a signed compare or an equality-only compare leaves the interrupt at the wrong level.

// File: rtl/psc_timer_pkg.sv
package psc_timer_pkg;

    localparam int DIV_W     = 8;   // prescaler divide field width
    localparam int SEL_W     = 2;   // clock-select field width
    localparam int ADDR_W    = 2;   // register address width
    localparam int DIV_LSB   = 16;  // divide field position in the control word
    localparam int SEL_LSB   = 26;  // clock-select field position
    localparam int DEFER_BIT = 31;  // deferred-update flag position

    localparam logic [ADDR_W-1:0] A_PSC = 2'd0;
    localparam logic [ADDR_W-1:0] A_CNT = 2'd1;
    localparam logic [ADDR_W-1:0] A_CMP = 2'd2;

    typedef struct packed {
        logic             defer;
        logic [SEL_W-1:0] sel;
        logic [DIV_W-1:0] div;
    } psc_cfg_t;

endpackage

// File: rtl/psc_timer_divider.sv
module psc_timer_divider
    import psc_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we_i,
    input  psc_cfg_t         cfg_i,
    output logic             tick_o,
    output logic [SEL_W-1:0] sel_o
);

    localparam int CNT_W = DIV_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [DIV_W-1:0] div;
        logic [SEL_W-1:0] sel;
        logic             pend_vld;
        logic [DIV_W-1:0] pend_div;
        logic [SEL_W-1:0] pend_sel;
    } div_state_t;

    div_state_t st_d, st_q;
    logic       carry;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        st_d     = st_q;
        last_cnt = {1'b0, st_q.div} + CNT_W'(1);
        carry    = (st_q.cnt == last_cnt);

        if (carry) begin
            st_d.cnt = '0;
            if (st_q.pend_vld) begin
                st_d.div      = st_q.pend_div;
                st_d.sel      = st_q.pend_sel;
                st_d.pend_vld = 1'b0;
            end
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end

        if (cfg_we_i) begin
            if (cfg_i.defer) begin
                st_d.pend_vld = 1'b1;
                st_d.pend_div = cfg_i.div;
                st_d.pend_sel = cfg_i.sel;
            end else begin
                st_d.div      = cfg_i.div;
                st_d.sel      = cfg_i.sel;
                st_d.cnt      = '0;
                st_d.pend_vld = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = carry;
    assign sel_o  = st_q.sel;

    AST_UNIT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (st_q.cnt == '0)) else $error("unit restart"); // R1

    AST_IMMEDIATE_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && !cfg_i.defer) |=> (st_q.div == $past(cfg_i.div) && st_q.cnt == '0 && !st_q.pend_vld))
        else $error("immediate apply"); // R5

    AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend_vld && !tick_o && !(cfg_we_i && !cfg_i.defer)) |=> $stable(st_q.div))
        else $error("deferred hold"); // R6

    AST_DEFER_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend_vld && tick_o && !(cfg_we_i && !cfg_i.defer)) |=> (st_q.div == $past(st_q.pend_div)))
        else $error("deferred apply"); // R6

    AST_SEL_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && !cfg_i.defer) |=> (sel_o == $past(cfg_i.sel)))
        else $error("select update"); // R8

endmodule

// File: rtl/psc_timer_core.sv
module psc_timer_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             cnt_we_i,
    input  logic             cmp_we_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] cmp;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cnt_we_i) begin
            st_d.count = wdata_i;
        end else if (tick_i) begin
            st_d.count = st_q.count + CNT_W'(1);
        end
        if (cmp_we_i) begin
            st_d.cmp = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.count <= '0;
            st_q.cmp   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;
    assign cmp_o   = st_q.cmp;
    assign irq_o   = (st_q.count >= st_q.cmp);

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !cnt_we_i) |=> (count_o == $past(count_o) + CNT_W'(1)))
        else $error("count step"); // R2

    AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !cnt_we_i) |=> $stable(count_o)) else $error("count idle"); // R2

    AST_COUNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !cnt_we_i && (&count_o)) |=> (count_o == '0)) else $error("wrap"); // R3

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we_i |=> (count_o == $past(wdata_i))) else $error("write wins"); // R9

    AST_IRQ_MAXCMP: assert property (@(posedge clk) disable iff (!rst_n)
        ((&cmp_o) && !(&count_o)) |-> !irq_o) else $error("irq max compare"); // R4

endmodule

// File: rtl/psc_timer_top.sv
module psc_timer_top
    import psc_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_waddr,
    input  logic [CNT_W-1:0]  reg_wdata,
    input  logic [ADDR_W-1:0] reg_raddr,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              tick_o,
    output logic              irq_o,
    output logic [SEL_W-1:0]  clk_sel_o
);

    logic             psc_we, cnt_we, cmp_we;
    psc_cfg_t         cfg;
    logic [CNT_W-1:0] count, cmp;

    assign psc_we = reg_we && (reg_waddr == A_PSC);
    assign cnt_we = reg_we && (reg_waddr == A_CNT);
    assign cmp_we = reg_we && (reg_waddr == A_CMP);

    assign cfg.defer = reg_wdata[DEFER_BIT];
    assign cfg.sel   = reg_wdata[SEL_LSB +: SEL_W];
    assign cfg.div   = reg_wdata[DIV_LSB +: DIV_W];

    psc_timer_divider u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we_i (psc_we),
        .cfg_i    (cfg),
        .tick_o   (tick_o),
        .sel_o    (clk_sel_o)
    );

    psc_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_o),
        .cnt_we_i (cnt_we),
        .cmp_we_i (cmp_we),
        .wdata_i  (reg_wdata),
        .count_o  (count),
        .cmp_o    (cmp),
        .irq_o    (irq_o)
    );

    always_comb begin
        case (reg_raddr)
            A_CNT:   reg_rdata = count;
            A_CMP:   reg_rdata = cmp;
            default: reg_rdata = '0;
        endcase
    end

    AST_PSC_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_raddr == A_PSC) |-> (reg_rdata == '0)) else $error("control read"); // R10

endmodule

// File: tb/tb_psc_timer_top.sv
module tb_psc_timer_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [1:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        tick_o, irq_o;
    logic [1:0]  clk_sel_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    psc_timer_top dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .tick_o(tick_o), .irq_o(irq_o), .clk_sel_o(clk_sel_o)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Called at a negedge; returns at the next negedge with the write done.
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    function automatic logic [31:0] psc_word(input bit defer, input logic [1:0] sel, input logic [7:0] n);
        return {defer, 3'b000, sel, 2'b00, n, 16'h0000};
    endfunction

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_raddr = a;
        #0.5;
        d = reg_rdata;
    endtask

    // Advances negedge by negedge until tick_o is seen; k = negedges taken.
    task automatic wait_tick(output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!tick_o && k < 2000);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        int k;
        rd(2'd1, d); check("R11", "count after reset", d, 0);
        rd(2'd2, d); check("R11", "compare after reset", d, 32'hFFFF_FFFF);
        check("R11", "irq after reset", irq_o, 0);
        check("R11", "select after reset", clk_sel_o, 0);
        wait_tick(k);
        wait_tick(k); check("R1", "default period n=0", k, 2);
    endtask

    task automatic t_immediate();
        int k;
        wr(2'd0, psc_word(1'b0, 2'd1, 8'd3));
        check("R8", "select after immediate write", clk_sel_o, 1);
        wait_tick(k); check("R1", "first tick after immediate write", k, 4);
        wait_tick(k); check("R5", "period after immediate n=3", k, 5);
    endtask

    task automatic t_step();
        logic [31:0] d;
        int k;
        wr(2'd0, psc_word(1'b0, 2'd1, 8'd2));
        wr(2'd1, 32'd100);
        wait_tick(k);
        rd(2'd1, d); check("R2", "count before carry edge", d, 100);
        @(negedge clk);
        rd(2'd1, d); check("R2", "count after one tick", d, 101);
        wait_tick(k);
        @(negedge clk);
        rd(2'd1, d); check("R2", "count after two ticks", d, 102);
    endtask

    task automatic t_defer();
        int k, t;
        // running n=2, sel=1, period 4
        wait_tick(k);
        @(negedge clk); t = 1;
        wr(2'd0, psc_word(1'b1, 2'd2, 8'd5)); t++;
        check("R6", "select held while pending", clk_sel_o, 1);
        wait_tick(k); t += k;
        check("R6", "unit in progress keeps old length", t, 4);
        check("R6", "select still old at boundary tick", clk_sel_o, 1);
        wait_tick(k); check("R6", "period after deferred apply", k, 7);
        check("R8", "deferred select applied", clk_sel_o, 2);
    endtask

    task automatic t_replace();
        int k, t;
        // running n=5, period 7
        wait_tick(k);
        @(negedge clk); t = 1;
        wr(2'd0, psc_word(1'b1, 2'd3, 8'd1)); t++;
        wr(2'd0, psc_word(1'b1, 2'd0, 8'd4)); t++;
        wait_tick(k); t += k;
        check("R7", "old unit length with two pending writes", t, 7);
        wait_tick(k); check("R7", "last pending period applied", k, 6);
        check("R7", "last pending select applied", clk_sel_o, 0);
    endtask

    task automatic t_defer_on_tick();
        int k;
        // running n=4, period 6; deferred write made in a tick cycle
        wait_tick(k);
        wr(2'd0, psc_word(1'b1, 2'd1, 8'd0));
        check("R6", "select unchanged after write in tick cycle", clk_sel_o, 0);
        wait_tick(k); check("R6", "unit after tick-cycle defer keeps old length", k, 5);
        wait_tick(k); check("R6", "tick-cycle defer applied at next boundary", k, 2);
    endtask

    task automatic t_race();
        logic [31:0] d;
        int k;
        wr(2'd0, psc_word(1'b0, 2'd0, 8'd0));
        wait_tick(k);
        wr(2'd1, 32'd555);
        rd(2'd1, d); check("R9", "count write beats tick", d, 555);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        int k;
        wr(2'd2, 32'd5);
        wr(2'd1, 32'hFFFF_FFFF);
        check("R4", "irq with max count", irq_o, 1);
        wait_tick(k);
        @(negedge clk);
        rd(2'd1, d); check("R3", "count wraps to zero", d, 0);
        check("R4", "irq clears after wrap", irq_o, 0);
    endtask

    task automatic t_compare();
        wr(2'd0, psc_word(1'b0, 2'd0, 8'd255));
        wr(2'd2, 32'd10);
        wr(2'd1, 32'd9);  check("R4", "count below compare", irq_o, 0);
        wr(2'd1, 32'd10); check("R4", "count equal compare", irq_o, 1);
        wr(2'd1, 32'd11); check("R4", "count above compare", irq_o, 1);
        wr(2'd2, 32'h7FFF_FFFF);
        wr(2'd1, 32'h8000_0001); check("R4", "unsigned compare across bit 31", irq_o, 1);
        wr(2'd2, 32'h8000_0000);
        wr(2'd1, 32'h7FFF_FFFF); check("R4", "unsigned below across bit 31", irq_o, 0);
    endtask

    task automatic t_readback();
        logic [31:0] d;
        wr(2'd2, 32'hA5A5_0F0F);
        rd(2'd2, d); check("R10", "compare readback", d, 32'hA5A5_0F0F);
        wr(2'd0, psc_word(1'b0, 2'd3, 8'd200));
        rd(2'd0, d); check("R10", "control word reads zero", d, 0);
        rd(2'd3, d); check("R10", "unused address reads zero", d, 0);
        check("R8", "select from bits 27..26", clk_sel_o, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_immediate();
        t_step();
        t_defer();
        t_replace();
        t_defer_on_tick();
        t_race();
        t_wrap();
        t_compare();
        t_readback();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule